// File: doc/BRIEF.md
# Programmable Word Alignment Controller

This block sits behind a word decoder on the receive side of a serial link and finds the word boundary in the deserialized stream. One received word arrives per clock. For each word the decoder reports whether its control field was invalid and whether the word was idle, and it passes on the received scrambled flag bit. When too many invalid words arrive in a row, the controller asks the deserializer to move the boundary by one bit. It then ignores its inputs for a fixed settle time, until the shifted words have come through the decoder. When enough valid words arrive in a row, it declares the link aligned.

Both thresholds live in writable registers. An enhanced mode also treats a flag bit that stops toggling as a sign of misalignment. An idle-lock mode lets only idle words count toward lock. The bit shifter itself is outside the block. The controller only drives the one-bit slip request and the aligned indication.

Top module: `word_align_fsm`

## Requirements
- R1: When the N-th consecutive bad word is sampled while not aligned, rxSlide goes high on the next cycle and stays high for exactly two cycles. A bad word is one with wordErr high, or a static-flag event under R5.
- R2: After the slip pulse the block waits 14 cycles with rxSlide low. Words sampled during the pulse and the wait have no effect. After the wait it starts a fresh search with every counter cleared.
- R3: cfgWrEn with cfgSel=0 loads the error threshold N from cfgData[7:0]. N resets to 2.
- R4: Outside the aligned state, aligned goes high on the cycle after the M-th consecutive good word is sampled. cfgWrEn with cfgSel=1 loads M from cfgData[9:0]. M resets to 256.
- R5: With enhancedMode high, a static-flag event occurs when wordFlag has held the same value for 32 consecutive sampled words. The run restarts after each slip. In the aligned state, one such event drops aligned on the next cycle.
- R6: While aligned, fewer than N consecutive wordErr words leave aligned high. The N-th one drops aligned on the next cycle, without a slip pulse.
- R7: Any bad word before lock resets the good-word count to zero.
- R8: A threshold written as 0 acts as 1. A write takes effect for words sampled after the write edge.
- R9: With idleLockMode high, a good word counts toward lock only if wordIdle is high. A good non-idle word resets the count to zero.
- R10: While rst is high at a clock edge, both outputs go low, all counters clear and both thresholds return to their defaults.
- R11: rxSlide and aligned are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| wordErr | input | 1 | Decoder reports an invalid control field for this word |
| wordFlag | input | 1 | Received scrambled flag bit |
| wordIdle | input | 1 | Decoder reports an idle word |
| enhancedMode | input | 1 | Enables static-flag detection |
| idleLockMode | input | 1 | Only idle words count toward lock |
| cfgWrEn | input | 1 | Threshold register write strobe |
| cfgSel | input | 1 | 0 selects the error threshold, 1 the good-word threshold |
| cfgData | input | 10 | Threshold write data |
| rxSlide | output | 1 | One-bit slip request to the deserializer |
| aligned | output | 1 | Word boundary locked |

## Verification
The assertions assume one decoded word per clock, with all inputs known from the first edge after reset. They also assume reset is held through at least one edge before it is released, so that the slip-pulse shape and cause checks see a defined previous value. The stimulus drives every input one time unit after the rising edge and starts with reset high for several edges. It keeps cfgWrEn a single-cycle strobe. It toggles the flag on every word except where a static run is wanted, so static-flag events come only from the stimulus meant to produce them.

// File: rtl/align_pkg.sv
package align_pkg;

  typedef enum logic [2:0] {
    ST_SEARCH,
    ST_LOCKING,
    ST_SLIP,
    ST_WAIT,
    ST_ALIGNED
  } alignState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic errInc;
    logic errClr;
    logic cleanInc;
    logic cleanClr;
    logic timInc;
    logic timClr;
    logic flagTrack;
  } alignStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic errHit;
    logic cleanHit;
    logic slipLast;
    logic settleLast;
    logic staticEvt;
  } alignStat_t;

endpackage

// File: rtl/align_datapath.sv
module align_datapath
  import align_pkg::*;
#(
  parameter int ERR_W         = 8,
  parameter int CLEAN_W       = 10,
  parameter int CFG_W         = 10,
  parameter int ERR_DEF       = 2,
  parameter int CLEAN_DEF     = 256,
  parameter int SLIP_CYCLES   = 2,
  parameter int SETTLE_CYCLES = 14,
  parameter int STATIC_LEN    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wordFlag,
  input  logic             enhancedMode,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [CFG_W-1:0] cfgData,
  input  alignStrobe_t     stb,
  output alignStat_t       stat
);

  localparam int TIM_MAX = (SLIP_CYCLES > SETTLE_CYCLES) ? SLIP_CYCLES : SETTLE_CYCLES;
  localparam int TIM_W   = $clog2(TIM_MAX + 1);
  localparam int RUN_W   = $clog2(STATIC_LEN + 1);
  localparam logic [TIM_W-1:0] SLIP_LAST   = TIM_W'(SLIP_CYCLES - 1);
  localparam logic [TIM_W-1:0] SETTLE_LAST = TIM_W'(SETTLE_CYCLES - 1);
  localparam logic [RUN_W-1:0] RUN_FULL    = RUN_W'(STATIC_LEN);
  localparam logic [ERR_W:0]   ERR_ONE     = 1;
  localparam logic [CLEAN_W:0] CLEAN_ONE   = 1;

  logic [ERR_W-1:0]   errThr, errEff, errCnt;
  logic [CLEAN_W-1:0] cleanThr, cleanEff, cleanCnt;
  logic [TIM_W-1:0]   timer;
  logic [RUN_W-1:0]   runLen, runNext;
  logic               flagPrev;

  // threshold registers
  always_ff @(posedge clk) begin
    if (rst) begin
      errThr   <= ERR_W'(ERR_DEF);
      cleanThr <= CLEAN_W'(CLEAN_DEF);
    end else if (cfgWrEn) begin
      if (cfgSel) cleanThr <= cfgData[CLEAN_W-1:0];
      else        errThr   <= cfgData[ERR_W-1:0];
    end
  end

  assign errEff   = (errThr == '0)   ? ERR_W'(1)   : errThr;
  assign cleanEff = (cleanThr == '0) ? CLEAN_W'(1) : cleanThr;

  // consecutive-word counters and settle timer
  always_ff @(posedge clk) begin
    if (rst) begin
      errCnt   <= '0;
      cleanCnt <= '0;
      timer    <= '0;
    end else begin
      if (stb.errClr)        errCnt   <= '0;
      else if (stb.errInc)   errCnt   <= errCnt + 1'b1;
      if (stb.cleanClr)      cleanCnt <= '0;
      else if (stb.cleanInc) cleanCnt <= cleanCnt + 1'b1;
      if (stb.timClr)        timer    <= '0;
      else if (stb.timInc)   timer    <= timer + 1'b1;
    end
  end

  // flag run-length tracker
  always_comb begin
    if (runLen != '0 && wordFlag == flagPrev)
      runNext = (runLen == RUN_FULL) ? runLen : runLen + 1'b1;
    else
      runNext = RUN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !stb.flagTrack) begin
      runLen   <= '0;
      flagPrev <= 1'b0;
    end else begin
      runLen   <= runNext;
      flagPrev <= wordFlag;
    end
  end

  assign stat.errHit     = ({1'b0, errCnt} + ERR_ONE) >= {1'b0, errEff};
  assign stat.cleanHit   = ({1'b0, cleanCnt} + CLEAN_ONE) >= {1'b0, cleanEff};
  assign stat.slipLast   = (timer == SLIP_LAST);
  assign stat.settleLast = (timer == SETTLE_LAST);
  assign stat.staticEvt  = enhancedMode && (runNext == RUN_FULL);

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    runLen <= RUN_FULL) else $error("run length overflow"); // R5
  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
    timer <= SETTLE_LAST) else $error("settle timer overflow"); // R2
  AST_ERR_BOUND: assert property (@(posedge clk) disable iff (rst)
    errCnt < errEff || $past(cfgWrEn)) else $error("error count past threshold"); // R1

endmodule

// File: rtl/align_ctrl.sv
module align_ctrl
  import align_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         wordErr,
  input  logic         wordIdle,
  input  logic         idleLockMode,
  input  alignStat_t   stat,
  output alignStrobe_t stb,
  output logic         rxSlide,
  output logic         aligned
);

  alignState_t state, nxt;
  logic        badWord;

  assign badWord = wordErr | stat.staticEvt;

  always_comb begin
    nxt           = state;
    stb           = '0;
    stb.flagTrack = (state == ST_SEARCH) || (state == ST_LOCKING) || (state == ST_ALIGNED);
    unique case (state)
      ST_SEARCH, ST_LOCKING: begin
        if (badWord) begin
          stb.cleanClr = 1'b1;
          if (stat.errHit) begin
            stb.errClr = 1'b1;
            stb.timClr = 1'b1;
            nxt        = ST_SLIP;
          end else begin
            stb.errInc = 1'b1;
            nxt        = ST_SEARCH;
          end
        end else begin
          stb.errClr = 1'b1;
          if (!idleLockMode || wordIdle) begin
            if (stat.cleanHit) begin
              stb.cleanClr = 1'b1;
              nxt          = ST_ALIGNED;
            end else begin
              stb.cleanInc = 1'b1;
              nxt          = ST_LOCKING;
            end
          end else begin
            stb.cleanClr = 1'b1;
            nxt          = ST_SEARCH;
          end
        end
      end
      ST_SLIP: begin
        if (stat.slipLast) begin
          stb.timClr = 1'b1;
          nxt        = ST_WAIT;
        end else stb.timInc = 1'b1;
      end
      ST_WAIT: begin
        if (stat.settleLast) begin
          stb.timClr   = 1'b1;
          stb.errClr   = 1'b1;
          stb.cleanClr = 1'b1;
          nxt          = ST_SEARCH;
        end else stb.timInc = 1'b1;
      end
      ST_ALIGNED: begin
        if (stat.staticEvt) begin
          stb.errClr = 1'b1;
          nxt        = ST_SEARCH;
        end else if (wordErr) begin
          if (stat.errHit) begin
            stb.errClr = 1'b1;
            nxt        = ST_SEARCH;
          end else stb.errInc = 1'b1;
        end else stb.errClr = 1'b1;
      end
      default: nxt = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_SEARCH;
    else     state <= nxt;
  end

  assign rxSlide = (state == ST_SLIP);
  assign aligned = (state == ST_ALIGNED);

  AST_SLIP_HOLD: assert property (@(posedge clk) disable iff (rst)
    rxSlide && !$past(rxSlide) |=> rxSlide) else $error("slip pulse too short"); // R1
  AST_SLIP_END: assert property (@(posedge clk) disable iff (rst)
    rxSlide && $past(rxSlide) |=> !rxSlide) else $error("slip pulse too long"); // R1
  AST_SLIP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(rxSlide) |-> $past(wordErr || stat.staticEvt)) else $error("slip without bad word"); // R1
  AST_NO_DIRECT_SLIP: assert property (@(posedge clk) disable iff (rst)
    aligned |=> !rxSlide) else $error("slip straight from aligned"); // R6
  AST_OUT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rxSlide && aligned)) else $error("slip and aligned together"); // R11

endmodule

// File: rtl/word_align_fsm.sv
module word_align_fsm
  import align_pkg::*;
#(
  parameter int ERR_W         = 8,
  parameter int CLEAN_W       = 10,
  parameter int ERR_DEF       = 2,
  parameter int CLEAN_DEF     = 256,
  parameter int SLIP_CYCLES   = 2,
  parameter int SETTLE_CYCLES = 14,
  parameter int STATIC_LEN    = 32,
  localparam int CFG_W        = (CLEAN_W > ERR_W) ? CLEAN_W : ERR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wordErr,
  input  logic             wordFlag,
  input  logic             wordIdle,
  input  logic             enhancedMode,
  input  logic             idleLockMode,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [CFG_W-1:0] cfgData,
  output logic             rxSlide,
  output logic             aligned
);

  alignStrobe_t stb;
  alignStat_t   stat;

  align_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .wordErr      (wordErr),
    .wordIdle     (wordIdle),
    .idleLockMode (idleLockMode),
    .stat         (stat),
    .stb          (stb),
    .rxSlide      (rxSlide),
    .aligned      (aligned)
  );

  align_datapath #(
    .ERR_W         (ERR_W),
    .CLEAN_W       (CLEAN_W),
    .CFG_W         (CFG_W),
    .ERR_DEF       (ERR_DEF),
    .CLEAN_DEF     (CLEAN_DEF),
    .SLIP_CYCLES   (SLIP_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .STATIC_LEN    (STATIC_LEN)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .wordFlag     (wordFlag),
    .enhancedMode (enhancedMode),
    .cfgWrEn      (cfgWrEn),
    .cfgSel       (cfgSel),
    .cfgData      (cfgData),
    .stb          (stb),
    .stat         (stat)
  );

endmodule

// File: tb/word_align_fsm_bench.sv
module word_align_fsm_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wordErr = 1'b0, wordFlag = 1'b0, wordIdle = 1'b0;
  logic enhancedMode = 1'b0, idleLockMode = 1'b0;
  logic cfgWrEn = 1'b0, cfgSel = 1'b0;
  logic [9:0] cfgData = '0;
  logic rxSlide, aligned;

  always #(CLK_PERIOD/2) clk = ~clk;

  word_align_fsm u_word_align_fsm (
    .clk(clk), .rst(rst), .wordErr(wordErr), .wordFlag(wordFlag), .wordIdle(wordIdle),
    .enhancedMode(enhancedMode), .idleLockMode(idleLockMode), .cfgWrEn(cfgWrEn),
    .cfgSel(cfgSel), .cfgData(cfgData), .rxSlide(rxSlide), .aligned(aligned)
  );

  typedef struct { int cyc; bit rx; bit al; string tag; } exp_t;
  exp_t expQ[$];
  int checks = 0, failures = 0, cycNow = 0;

  // requirement-level model state (0 hunting, 1 slip, 2 settle, 3 locked)
  int mSt = 0, mErr = 0, mGood = 0, mTim = 0, mRun = 0, thrN = 2, thrM = 256;
  bit mPrev = 0;

  always @(posedge clk) cycNow <= cycNow + 1;

  // monitor: pop and compare expectations away from the active edge
  always @(negedge clk) begin
    exp_t it;
    while (expQ.size() > 0 && expQ[0].cyc <= cycNow) begin
      it = expQ.pop_front();
      checks++;
      if (rxSlide !== it.rx || aligned !== it.al) begin
        failures++;
        $display("FAIL %s cycle %0d: rxSlide/aligned actual=%b%b expected=%b%b",
                 it.tag, cycNow, rxSlide, aligned, it.rx, it.al);
      end
      checks++;
      if (rxSlide === 1'b1 && aligned === 1'b1) begin
        failures++;
        $display("FAIL R11 cycle %0d: actual=both high expected=not both", cycNow);
      end
    end
  end

  task automatic step(bit e, bit idl, string tag);
    int effN, effM, runNext;
    bit trk, stat;
    wordErr = e; wordIdle = idl;
    if (rst) begin
      mSt = 0; mErr = 0; mGood = 0; mTim = 0; mRun = 0; mPrev = 0; thrN = 2; thrM = 256;
    end else begin
      effN = (thrN == 0) ? 1 : thrN;
      effM = (thrM == 0) ? 1 : thrM;
      trk  = (mSt == 0 || mSt == 3);
      runNext = (mRun != 0 && wordFlag == mPrev) ? ((mRun == 32) ? 32 : mRun + 1) : 1;
      stat = enhancedMode && runNext == 32;
      case (mSt)
        0: if (e || stat) begin
             mGood = 0;
             if (mErr + 1 >= effN) begin mSt = 1; mErr = 0; mTim = 0; end else mErr++;
           end else begin
             mErr = 0;
             if (!idleLockMode || idl) begin
               if (mGood + 1 >= effM) begin mSt = 3; mGood = 0; end else mGood++;
             end else mGood = 0;
           end
        1: if (mTim == 1) begin mSt = 2; mTim = 0; end else mTim++;
        2: if (mTim == 13) begin mSt = 0; mTim = 0; mErr = 0; mGood = 0; end else mTim++;
        default: if (stat) begin mSt = 0; mErr = 0; end
                 else if (e) begin
                   if (mErr + 1 >= effN) begin mSt = 0; mErr = 0; end else mErr++;
                 end else mErr = 0;
      endcase
      if (trk) begin mRun = runNext; mPrev = wordFlag; end else begin mRun = 0; mPrev = 0; end
      if (cfgWrEn) begin
        if (cfgSel) thrM = cfgData; else thrN = cfgData[7:0];
      end
    end
    expQ.push_back('{cycNow + 1, (mSt == 1), (mSt == 3), tag});
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
  endtask

  task automatic runWords(int n, bit e, bit idl, bit toggle, string tag);
    for (int k = 0; k < n; k++) begin
      if (toggle) wordFlag = ~wordFlag;
      step(e, idl, tag);
    end
  endtask

  task automatic cfgWrite(bit sel, int val, string tag);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = 10'(val);
    wordFlag = ~wordFlag;
    step(1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    step(1'b0, 1'b0, "R10");                 // reset state, outputs low
    rst = 1'b0;
    runWords(256, 0, 0, 1, "R4");            // default M=256 locks on the 256th
    runWords(1, 1, 0, 1, "R6");              // single error keeps lock
    runWords(3, 0, 0, 1, "R6");
    runWords(2, 1, 0, 1, "R6");              // N=2 errors drop lock, no slip
    runWords(1, 1, 0, 1, "R1");
    runWords(1, 0, 0, 1, "R7");              // clean word breaks the error run
    runWords(2, 1, 0, 1, "R1");              // slip requested
    runWords(2, 1, 0, 1, "R1");              // two-cycle pulse
    runWords(14, 1, 0, 1, "R2");             // settle: errors ignored
    runWords(1, 1, 0, 1, "R2");              // fresh count after settle
    runWords(1, 0, 0, 1, "R2");
    cfgWrite(0, 5, "R3");                    // N = 5
    runWords(4, 1, 0, 1, "R3");
    runWords(1, 1, 0, 1, "R3");              // fifth error slips
    runWords(16, 0, 0, 1, "R2");
    cfgWrite(1, 8, "R8");                    // M = 8
    runWords(5, 0, 0, 1, "R7");
    runWords(1, 1, 0, 1, "R7");              // resets good count
    runWords(7, 0, 0, 1, "R7");
    runWords(1, 0, 0, 1, "R7");              // eighth consecutive good word locks
    cfgWrite(1, 0, "R8");                    // M written as 0
    runWords(5, 1, 0, 1, "R6");              // N=5 errors drop lock
    runWords(1, 0, 0, 1, "R8");              // one good word locks
    enhancedMode = 1'b1;
    runWords(40, 0, 0, 0, "R5");             // static flag drops lock, then slips
    runWords(20, 0, 0, 1, "R5");
    runWords(3, 0, 0, 1, "R5");
    cfgWrite(1, 4, "R9");
    enhancedMode = 1'b0;
    idleLockMode = 1'b1;
    runWords(5, 1, 0, 1, "R9");              // leave lock
    runWords(6, 0, 0, 1, "R9");              // non-idle good words do not count
    runWords(3, 0, 1, 1, "R9");
    runWords(1, 0, 0, 1, "R9");              // non-idle word resets count
    runWords(4, 0, 1, 1, "R9");              // fourth idle word locks
    idleLockMode = 1'b0;
    rst = 1'b1;
    step(1'b0, 1'b0, "R10");
    rst = 1'b0;
    runWords(2, 1, 0, 1, "R10");             // default N=2 restored
    runWords(3, 0, 0, 1, "R10");
    @(negedge clk);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog (all requirements): actual=still running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule